// File: doc/BRIEF.md
# Flash program status and interrupt controller

This block sits between software-visible control bits and a flash programming engine. Software sets a program-enable bit, selects a program width, and then issues data writes to flash addresses. The block screens each write for sequence, width, alignment and protection faults. It starts a fixed-length busy period for every write that passes the screen. A write that arrives while an operation is running waits in a single holding slot, so that back-to-back writes form one continuous busy burst.

Status is a set of sticky write-1-to-clear flags. These are an end-of-operation flag, four error flags and an error summary flag. A single interrupt line is raised from the two enabled summary terms. Error flags cannot be cleared while a burst is in progress. Software therefore sees every fault of a burst after it has finished.

The sequencer has three states. IDLE means no operation is running. PROG means the timer is running and the holding slot is empty. HELD means the timer is running and one write is waiting. These are the transitions:
- IDLE→PROG on an accepted write.
- PROG→HELD on an accepted write before the timer ends.
- PROG→IDLE when the timer ends with no new write.
- PROG→PROG when the timer ends in the same cycle a write is accepted (the timer reloads).
- HELD→PROG when the timer ends and the held write starts.
- HELD→HELD when the timer ends in the same cycle as a further accepted write.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, busy is 0, all six status bits are 0 and irq is 0.
- R2: A write that raises no error holds busy high for exactly PROG_CYCLES consecutive cycles, starting with the edge that samples the write.
- R3: The end-of-operation flag (sts[0]) is set on the edge where busy falls, and only if the end-of-operation enable is 1 at that time. Otherwise it is not set.
- R4: A write issued while the program-enable bit is 0 sets the sequence error flag (sts[5]) and starts no operation.
- R5: A write whose address has any of its low psize bits set sets the alignment error flag (sts[3]). The psize encoding is 0 for byte, 1 for halfword, 2 for word and 3 for doubleword, and the address must be a multiple of 2^psize.
- R6: A write whose size field differs from the configured psize sets the parallelism error flag (sts[4]).
- R7: A write to an address in the range PROT_BASE to PROT_TOP, inclusive, sets the write-protection error flag (sts[2]).
- R8: When any error is detected and the error enable is 1, the operation-error flag (sts[1]) is set. With the error enable at 0 it is not set.
- R9: A valid write that arrives while busy and with the holding slot empty is held. It then extends busy by another PROG_CYCLES cycles without a gap, and only one end-of-operation event occurs. A write that arrives while the slot is full sets the sequence error flag and is dropped.
- R10: Status flags clear on clr_valid with a 1 in the matching clr_mask bit. Clears of sts[5:1] are ignored while busy is high. sts[0] clears at any time. A set in the same cycle as a clear wins.
- R11: irq equals (sts[0] AND eop enable) OR (sts[1] AND error enable), and it stays high until the flag is cleared or the enable is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Load the control fields below |
| ctl_pg | input | 1 | Program-enable value |
| ctl_eopie | input | 1 | End-of-operation interrupt enable value |
| ctl_errie | input | 1 | Error interrupt enable value |
| ctl_psize | input | 2 | Program width value, log2 of bytes |
| clr_valid | input | 1 | Status clear strobe |
| clr_mask | input | 6 | Write-1-to-clear mask, same bit order as sts |
| wr_valid | input | 1 | Flash data write request |
| wr_addr | input | AW | Byte address of the write |
| wr_size | input | 2 | Width of the write, log2 of bytes |
| busy | output | 1 | Operation or burst in progress |
| sts | output | 6 | {seq, par, align, wp, operr, eop} |
| irq | output | 1 | Interrupt request |

## Verification
Every flag and busy are registered on the edge that samples the write or clear. The bench drives inputs on the falling edge and reads results on the next falling edge, which is one cycle after the stimulus. The end-of-operation flag lands on the same edge where busy falls, so the bench counts busy samples and checks sts[0] at the first sample where busy is low. irq is combinational from the flags and the enables, so it is checked in the same sample as the flag it follows.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PROG = 2'd1,
        S_HELD = 2'd2
    } fpc_state_e;

    localparam int unsigned N_ERR  = 4;
    localparam int unsigned N_STS  = N_ERR + 2;
    localparam int unsigned B_EOP  = 0;
    localparam int unsigned B_OPER = 1;
    localparam int unsigned B_ERR0 = 2;
    localparam int unsigned E_WP   = 0;
    localparam int unsigned E_ALN  = 1;
    localparam int unsigned E_PAR  = 2;
    localparam int unsigned E_SEQ  = 3;
endpackage

// File: rtl/fpc_err_chk.sv
module fpc_err_chk
    import fpc_pkg::*;
#(
    parameter int unsigned AW        = 16,
    parameter int unsigned PROT_BASE = 'hF000,
    parameter int unsigned PROT_TOP  = 'hFFFF
) (
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [1:0]    wr_size,
    input  logic          pg,
    input  logic [1:0]    psize,
    output logic [N_ERR-1:0] err
);
    localparam logic [AW-1:0] LO = AW'(PROT_BASE);
    localparam logic [AW-1:0] HI = AW'(PROT_TOP);

    logic [AW-1:0] aln_mask;

    always_comb begin
        aln_mask   = (AW'(1) << psize) - AW'(1);
        err        = '0;
        err[E_SEQ] = wr_valid && !pg;
        err[E_PAR] = wr_valid && (wr_size != psize);
        err[E_ALN] = wr_valid && ((wr_addr & aln_mask) != '0);
        err[E_WP]  = wr_valid && (wr_addr >= LO) && (wr_addr <= HI);
    end
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
    import fpc_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ok,
    output logic busy,
    output logic op_end,
    output logic overrun
);
    localparam int unsigned CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(PROG_CYCLES - 1);

    fpc_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          done, accept;

    always_comb begin
        done    = (state_q != S_IDLE) && (cnt_q == '0);
        accept  = wr_ok && ((state_q != S_HELD) || done);
        state_d = state_q;
        cnt_d   = (cnt_q != '0) ? cnt_q - CW'(1) : cnt_q;
        unique case (state_q)
            S_IDLE: if (accept) begin
                state_d = S_PROG;
                cnt_d   = RELOAD;
            end
            S_PROG: begin
                if (done) begin
                    state_d = accept ? S_PROG : S_IDLE;
                    cnt_d   = RELOAD;
                end else if (accept) begin
                    state_d = S_HELD;
                end
            end
            S_HELD: if (done) begin
                state_d = accept ? S_HELD : S_PROG;
                cnt_d   = RELOAD;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy    = (state_q != S_IDLE);
        op_end  = (state_q == S_PROG) && done && !accept;
        overrun = wr_ok && (state_q == S_HELD) && !done;
    end

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RELOAD);
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && wr_ok) |=> busy);
    a_r9_chain_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HELD) |=> busy);
endmodule

// File: rtl/fpc_flags.sv
module fpc_flags
    import fpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             op_end,
    input  logic [N_ERR-1:0] err,
    input  logic             eopie,
    input  logic             errie,
    input  logic             clr_valid,
    input  logic [N_STS-1:0] clr_mask,
    output logic [N_STS-1:0] sts
);
    logic [N_ERR-1:0] err_q;
    logic             eop_q, oper_q;
    logic             lock;

    assign lock = busy;

    generate
        for (genvar i = 0; i < N_ERR; i++) begin : g_err
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    err_q[i] <= 1'b0;
                else if (err[i])
                    err_q[i] <= 1'b1;
                else if (clr_valid && clr_mask[B_ERR0+i] && !lock)
                    err_q[i] <= 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eop_q  <= 1'b0;
            oper_q <= 1'b0;
        end else begin
            if (op_end && eopie)
                eop_q <= 1'b1;
            else if (clr_valid && clr_mask[B_EOP])
                eop_q <= 1'b0;
            if ((|err) && errie)
                oper_q <= 1'b1;
            else if (clr_valid && clr_mask[B_OPER] && !lock)
                oper_q <= 1'b0;
        end
    end

    assign sts = {err_q, oper_q, eop_q};

    a_r3_eop_set: assert property (@(posedge clk) disable iff (!rst_n)
        (op_end && eopie) |=> eop_q);
    a_r3_eop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eop_q) |-> $past(op_end));
    a_r8_operr_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((|err) && errie) |=> oper_q);
    a_r10_err_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (($past(err_q) & ~err_q) == '0));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import fpc_pkg::*;
#(
    parameter int unsigned AW          = 16,
    parameter int unsigned PROG_CYCLES = 8,
    parameter int unsigned PROT_BASE   = 'hF000,
    parameter int unsigned PROT_TOP    = 'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          ctl_pg,
    input  logic          ctl_eopie,
    input  logic          ctl_errie,
    input  logic [1:0]    ctl_psize,
    input  logic          clr_valid,
    input  logic [5:0]    clr_mask,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [1:0]    wr_size,
    output logic          busy,
    output logic [5:0]    sts,
    output logic          irq
);
    logic             pg_q, eopie_q, errie_q;
    logic [1:0]       psize_q;
    logic [N_ERR-1:0] chk_err, all_err;
    logic             op_end, overrun;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q    <= 1'b0;
            eopie_q <= 1'b0;
            errie_q <= 1'b0;
            psize_q <= 2'd0;
        end else if (ctl_we) begin
            pg_q    <= ctl_pg;
            eopie_q <= ctl_eopie;
            errie_q <= ctl_errie;
            psize_q <= ctl_psize;
        end
    end

    fpc_err_chk #(.AW(AW), .PROT_BASE(PROT_BASE), .PROT_TOP(PROT_TOP)) u_chk (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_size  (wr_size),
        .pg       (pg_q),
        .psize    (psize_q),
        .err      (chk_err)
    );

    fpc_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (wr_valid && (chk_err == '0)),
        .busy    (busy),
        .op_end  (op_end),
        .overrun (overrun)
    );

    always_comb begin
        all_err        = chk_err;
        all_err[E_SEQ] = chk_err[E_SEQ] | overrun;
    end

    fpc_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .op_end    (op_end),
        .err       (all_err),
        .eopie     (eopie_q),
        .errie     (errie_q),
        .clr_valid (clr_valid),
        .clr_mask  (clr_mask),
        .sts       (sts)
    );

    assign irq = (sts[B_EOP] && eopie_q) || (sts[B_OPER] && errie_q);

    a_r11_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_valid && !ctl_we) |=> irq);
    a_r4_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_valid && !pg_q) |=> !busy);
endmodule

// File: tb/flash_prog_ctrl_test.sv
module flash_prog_ctrl_test;
    localparam int PC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 0, ctl_pg = 0, ctl_eopie = 0, ctl_errie = 0;
    logic [1:0] ctl_psize = 0;
    logic clr_valid = 0;
    logic [5:0] clr_mask = 0;
    logic wr_valid = 0;
    logic [15:0] wr_addr = 0;
    logic [1:0] wr_size = 0;
    logic busy, irq;
    logic [5:0] sts;

    int errors = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_prog_ctrl #(.AW(16), .PROG_CYCLES(PC), .PROT_BASE('hF000), .PROT_TOP('hFFFF)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_pg(ctl_pg),
        .ctl_eopie(ctl_eopie), .ctl_errie(ctl_errie), .ctl_psize(ctl_psize),
        .clr_valid(clr_valid), .clr_mask(clr_mask), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_size(wr_size), .busy(busy), .sts(sts), .irq(irq)
    );

    // {pg, psize, size, addr, expected {seq, par, align, wp}}
    localparam logic [24:0] VEC [0:7] = '{
        {1'b1, 2'd2, 2'd2, 16'h0100, 4'b0000},
        {1'b0, 2'd2, 2'd2, 16'h0100, 4'b1000},
        {1'b1, 2'd2, 2'd2, 16'h0102, 4'b0010},
        {1'b1, 2'd1, 2'd2, 16'h0100, 4'b0100},
        {1'b1, 2'd2, 2'd2, 16'hF000, 4'b0001},
        {1'b1, 2'd3, 2'd3, 16'h0104, 4'b0010},
        {1'b1, 2'd0, 2'd0, 16'h0103, 4'b0000},
        {1'b0, 2'd1, 2'd0, 16'hF001, 4'b1111}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ctl(input logic pg, input logic eie, input logic rie, input logic [1:0] ps);
        @(negedge clk);
        ctl_we = 1; ctl_pg = pg; ctl_eopie = eie; ctl_errie = rie; ctl_psize = ps;
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic wr_start(input logic [15:0] a, input logic [1:0] sz);
        wr_valid = 1; wr_addr = a; wr_size = sz;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic clr(input logic [5:0] m);
        clr_valid = 1; clr_mask = m;
        @(negedge clk);
        clr_valid = 0;
    endtask

    task automatic idle_wait();
        for (int i = 0; i < 4 * PC && busy; i++) @(negedge clk);
    endtask

    int n;

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 sts", sts, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1;
        @(negedge clk);

        // vector table: R4 R5 R6 R7 R8
        for (int v = 0; v < 8; v++) begin
            set_ctl(VEC[v][24], 1'b0, 1'b1, VEC[v][23:22]);
            wr_start(VEC[v][19:4], VEC[v][21:20]);
            chk($sformatf("R4/R5/R6/R7 err v%0d", v), sts[5:2], VEC[v][3:0]);
            chk($sformatf("R8 operr v%0d", v), sts[1], VEC[v][3:0] != 0);
            chk($sformatf("R2/R4 busy v%0d", v), busy, VEC[v][3:0] == 0);
            idle_wait();
            clr(6'h3F);
            chk($sformatf("R10 cleared v%0d", v), sts, 0);
        end

        // R2, R3, R11: busy length and eop
        set_ctl(1, 1, 1, 2'd2);
        wr_start(16'h0200, 2'd2);
        n = 0;
        while (busy && n < 4 * PC) begin
            if (n == PC - 1) chk("R3 eop not before fall", sts[0], 0);
            n++;
            @(negedge clk);
        end
        chk("R2 busy cycles", n, PC);
        chk("R3 eop at fall", sts[0], 1);
        chk("R11 irq eop", irq, 1);
        repeat (5) @(negedge clk);
        chk("R11 irq held", irq, 1);
        set_ctl(1, 0, 1, 2'd2);
        chk("R11 irq gated by enable", irq, 0);
        clr(6'h01);
        chk("R10 eop clear", sts[0], 0);

        // R3: eop disabled
        wr_start(16'h0204, 2'd2);
        idle_wait();
        @(negedge clk);
        chk("R3 eop not set when disabled", sts[0], 0);

        // R9: back-to-back burst and overrun
        set_ctl(1, 1, 1, 2'd2);
        wr_start(16'h0300, 2'd2);
        wr_start(16'h0304, 2'd2);
        wr_start(16'h0308, 2'd2);
        chk("R9 overrun seq", sts[5], 1);
        n = 2;
        while (busy && n < 6 * PC) begin
            if (sts[0]) chk("R9 no eop mid-burst", sts[0], 0);
            n++;
            @(negedge clk);
        end
        chk("R9 burst length", n, 2 * PC);
        chk("R9 eop after burst", sts[0], 1);
        clr(6'h3F);
        chk("R10 idle clear", sts, 0);

        // R10: error clear ignored during busy, eop clear allowed
        wr_start(16'h0400, 2'd2);
        @(negedge clk);
        wr_start(16'h0401, 2'd2);
        chk("R5 align during busy", sts[3], 1);
        clr(6'h3E);
        chk("R10 clear ignored busy", sts[5:1], 5'b00101);
        idle_wait();
        chk("R3 eop after op", sts[0], 1);
        wr_start(16'h0500, 2'd2);
        clr(6'h01);
        chk("R10 eop clear while busy", sts[0], 0);
        chk("R10 align still set", sts[3], 1);
        idle_wait();
        clr(6'h3F);
        chk("R10 clear after burst", sts, 0);

        // R8, R11: error enable off
        set_ctl(1, 0, 0, 2'd2);
        wr_start(16'h0601, 2'd2);
        chk("R5 align flag", sts[3], 1);
        chk("R8 operr gated", sts[1], 0);
        chk("R11 irq off", irq, 0);
        clr(6'h3F);
        set_ctl(1, 0, 1, 2'd2);
        wr_start(16'hF100, 2'd2);
        chk("R7 wp flag", sts[2], 1);
        chk("R11 irq error", irq, 1);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule